// File: doc/BRIEF.md
# Paced Peripheral Request Handler

This block serves one DMA channel that is paced by a peripheral. A table holds one packed control word for each of the peripheral request lines. Each word sets five things: how many accesses a request triggers, the access width, the direction, the byte-swap and initiator-port attributes, and a holdoff delay. The channel selects one request line. A request on that line starts a burst of single accesses to a device address. The accesses go out on a simple request/acknowledge port to the memory side.

After the last access of a burst, the handler waits out the holdoff. Only then does it look at the request line again. Request inputs are level-sensitive, so a peripheral that holds its line high gets one burst per holdoff period. In free-running mode the channel ignores the request inputs. It uses the control word of line 0 and issues bursts back to back, separated only by the holdoff.

Two conditions set a sticky error flag and issue no access: a paced channel mapped to one of the two reserved lines, and a control word with an unsupported width code. The flag clears when the channel is disabled.

Top module: `paced_req_handler`

## Requirements
- R1: Request inputs pass through two synchronising flops. When the selected line is high and the handler is idle, `acc_req` rises after the third rising clock edge that follows the rise of the line.
- R2: Bits 31:24 of the control word hold N. Each accepted request issues exactly N+1 accesses, and each access completes on a clock edge where `acc_req` and `acc_ack` are both high.
- R3: Bits 7:4 of the control word hold the width code. Codes 0 to 6 mean 1, 2, 4, 8, 16, 32 and 64 bytes, and the code is presented on `acc_size` during the burst.
- R4: Bit 14 of the control word gives the direction. When it is 1, `acc_write` is 1 (memory to device). When it is 0, `acc_write` is 0 (read from device).
- R5: Bit 21 of the control word enables address increment. When it is 1, the first access uses `dev_addr` and each later access adds 2^code bytes. When it is 0, every access uses `dev_addr`. The address and size hold steady while an access waits for `acc_ack`.
- R6: Bit 17 of the control word drives `acc_swap` and bit 22 drives `acc_port` for the whole burst. Bits 23, 20:18, 16:15, 13:8 and 3 have no effect.
- R7: Bits 2:0 of the control word hold a holdoff H. After the edge that completes the last access, the handler stays quiet for H cycles and is idle for one further cycle before it can accept the next request. A line held high therefore produces repeated bursts.
- R8: Requests on lines other than the selected one cause no access. A request is sampled only while the handler is idle and the channel is enabled (`ch_en` = 1).
- R9: With `ch_paced` = 0 the channel is free-running. It uses the control word of line 0, ignores all request inputs, and starts a new burst whenever it is idle and enabled.
- R10: A paced channel mapped to line 0 or to line NLINES-1 issues no access. While it is enabled, `cfg_err` becomes 1.
- R11: A width code from 7 to 15 in the selected word suppresses the burst. When a request is seen, `cfg_err` becomes 1.
- R12: `cfg_err` stays 1 while `ch_en` is 1. It clears one edge after `ch_en` is sampled 0. A burst already started runs to completion even if `ch_en` drops.
- R13: After reset `acc_req` and `cfg_err` are 0 and every control word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| dreq_i | input | NLINES | Level-sensitive peripheral request lines |
| cfg_we | input | 1 | Write strobe for the control table |
| cfg_line | input | log2(NLINES) | Table entry written |
| cfg_word | input | 32 | Control word written |
| ch_en | input | 1 | Channel enable |
| ch_paced | input | 1 | 1 = paced by a request line, 0 = free-running |
| ch_line | input | log2(NLINES) | Request line mapped to the channel |
| dev_addr | input | AW | Device address of the first access |
| acc_req | output | 1 | Access request to the memory side |
| acc_ack | input | 1 | Access accepted |
| acc_addr | output | AW | Access address |
| acc_size | output | 3 | Width code of the access |
| acc_write | output | 1 | 1 = write to device, 0 = read from device |
| acc_swap | output | 1 | Byte-swap attribute |
| acc_port | output | 1 | Initiator port select |
| cfg_err | output | 1 | Sticky configuration error |

## Verification
A request becomes visible as `acc_req` three rising edges after the line rises. Each later access follows one edge after the acknowledge that completes the previous one. The holdoff adds H quiet cycles plus one idle cycle before the next sample, and `cfg_err` changes one edge after the idle-state evaluation or the disable.

The bench models these delays behaviourally and clocks its model on the same rising edges as the design. It compares every output with the model on each falling edge, so both sides have settled before the comparison. Directed checks count the three-edge request latency exactly and observe the suppressed and ignored cases at the ports for several cycles.

// File: rtl/paced_req_handler.sv
module paced_req_handler #(
  parameter int NLINES = 32,
  parameter int AW = 32,
  localparam int LW = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] dreq_i,
  input  logic              cfg_we,
  input  logic [LW-1:0]     cfg_line,
  input  logic [31:0]       cfg_word,
  input  logic              ch_en,
  input  logic              ch_paced,
  input  logic [LW-1:0]     ch_line,
  input  logic [AW-1:0]     dev_addr,
  output logic              acc_req,
  input  logic              acc_ack,
  output logic [AW-1:0]     acc_addr,
  output logic [2:0]        acc_size,
  output logic              acc_write,
  output logic              acc_swap,
  output logic              acc_port,
  output logic              cfg_err
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_HOLD} state_t;

  typedef struct packed {
    logic [7:0] ops;
    logic       port;
    logic       inc;
    logic       swap;
    logic       wr;
    logic [3:0] code;
    logic [2:0] hold;
  } entry_t;

  state_t            state;
  entry_t            tbl [NLINES];
  entry_t            pick;
  logic [NLINES-1:0] sync1, sync2;
  logic [7:0]        ops_left;
  logic [2:0]        hold, hcnt;
  logic              inc_r;

  wire cfg_unused = ^{cfg_word[23], cfg_word[20:18], cfg_word[16:15], cfg_word[13:8], cfg_word[3]};

  assign pick = tbl[ch_paced ? ch_line : LW'(0)];

  wire reserved  = ch_paced && (ch_line == LW'(0) || ch_line == LW'(NLINES-1));
  wire want      = ch_en && (!ch_paced || sync2[ch_line]);
  wire bad_width = pick.code > 4'd6;
  wire in_idle   = state == S_IDLE;
  wire start     = in_idle && want && !reserved && !bad_width;

  assign acc_req = state == S_ISSUE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) tbl[i] <= '0;
    end else if (cfg_we) begin
      tbl[cfg_line] <= '{ops: cfg_word[31:24], port: cfg_word[22], inc: cfg_word[21],
                         swap: cfg_word[17], wr: cfg_word[14], code: cfg_word[7:4],
                         hold: cfg_word[2:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= dreq_i;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      ops_left  <= '0;
      hold      <= '0;
      hcnt      <= '0;
      inc_r     <= 1'b0;
      acc_addr  <= '0;
      acc_size  <= '0;
      acc_write <= 1'b0;
      acc_swap  <= 1'b0;
      acc_port  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state     <= S_ISSUE;
          ops_left  <= pick.ops;
          hold      <= pick.hold;
          inc_r     <= pick.inc;
          acc_size  <= pick.code[2:0];
          acc_write <= pick.wr;
          acc_swap  <= pick.swap;
          acc_port  <= pick.port;
          acc_addr  <= dev_addr;
        end
        S_ISSUE: if (acc_ack) begin
          if (ops_left == 8'd0) begin
            if (hold == 3'd0) state <= S_IDLE;
            else begin
              state <= S_HOLD;
              hcnt  <= hold;
            end
          end else begin
            ops_left <= ops_left - 8'd1;
            if (inc_r) acc_addr <= acc_addr + (AW'(1) << acc_size);
          end
        end
        S_HOLD: begin
          hcnt <= hcnt - 3'd1;
          if (hcnt == 3'd1) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_err <= 1'b0;
    else if (!ch_en) cfg_err <= 1'b0;
    else if (in_idle && (reserved || (want && bad_width))) cfg_err <= 1'b1;
  end

  AST_WAIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && !acc_ack |=> acc_req && $stable(acc_addr) && $stable(acc_size)); // R5
  AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_req) |-> !$past(ch_paced && (ch_line == LW'(0) || ch_line == LW'(NLINES-1)))); // R10
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err && ch_en |=> cfg_err); // R12
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req |-> acc_size <= 3'd6); // R11
  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_req) |-> $past(ch_en)); // R8

endmodule

// File: tb/paced_req_handler_test.sv
module paced_req_handler_test;
  logic        clk = 0, rst_n = 0;
  logic [31:0] dreq = '0;
  logic        cfg_we = 0;
  logic [4:0]  cfg_line = '0;
  logic [31:0] cfg_word = '0;
  logic        ch_en = 0, ch_paced = 0;
  logic [4:0]  ch_line = '0;
  logic [31:0] dev_addr = 32'h4000_0100;
  logic        acc_ack = 0;
  logic        acc_req, acc_write, acc_swap, acc_port, cfg_err;
  logic [31:0] acc_addr;
  logic [2:0]  acc_size;

  int    checks = 0, errors = 0;
  string tag = "R13";
  bit    ack_rand = 0, cmp_on = 0;
  logic [7:0] lfsr = 8'h5a;

  always #2.5 clk = ~clk;

  paced_req_handler uut (
    .clk(clk), .rst_n(rst_n), .dreq_i(dreq), .cfg_we(cfg_we), .cfg_line(cfg_line),
    .cfg_word(cfg_word), .ch_en(ch_en), .ch_paced(ch_paced), .ch_line(ch_line),
    .dev_addr(dev_addr), .acc_req(acc_req), .acc_ack(acc_ack), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_write(acc_write), .acc_swap(acc_swap),
    .acc_port(acc_port), .cfg_err(cfg_err));

  task automatic chk(string t, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", t, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk(int ops, int code, bit wr, bit sw, bit inc, bit po, int hold);
    logic [31:0] w = 32'h0080_0108;
    w[31:24] = ops[7:0];
    w[7:4]   = code[3:0];
    w[14]    = wr;
    w[17]    = sw;
    w[21]    = inc;
    w[22]    = po;
    w[2:0]   = hold[2:0];
    return w;
  endfunction

  // behavioural reference
  int          m_st, m_left, m_hc, m_h, m_sz;
  logic [31:0] m_a, m_s1, m_s2, w;
  bit          m_wr, m_sw, m_inc, m_po, m_err;
  logic [31:0] m_w [32];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_left = 0; m_hc = 0; m_h = 0; m_sz = 0; m_a = 0;
      m_wr = 0; m_sw = 0; m_inc = 0; m_po = 0; m_err = 0; m_s1 = 0; m_s2 = 0;
      for (int i = 0; i < 32; i++) m_w[i] = 0;
    end else begin
      case (m_st)
        0: begin
          w = ch_paced ? m_w[ch_line] : m_w[0];
          if (ch_en && ch_paced && (ch_line == 0 || ch_line == 31)) m_err = 1;
          else if (ch_en && (!ch_paced || m_s2[ch_line])) begin
            if (w[7:4] > 6) m_err = 1;
            else begin
              m_st = 1; m_left = int'(w[31:24]); m_sz = int'(w[7:4]);
              m_wr = w[14]; m_sw = w[17]; m_inc = w[21]; m_po = w[22];
              m_h = int'(w[2:0]); m_a = dev_addr;
            end
          end
        end
        1: if (acc_ack) begin
          if (m_left == 0) begin
            if (m_h == 0) m_st = 0;
            else begin m_st = 2; m_hc = m_h; end
          end else begin
            m_left--;
            if (m_inc) m_a = m_a + (32'd1 << m_sz);
          end
        end
        default: begin
          if (m_hc == 1) m_st = 0;
          m_hc--;
        end
      endcase
      if (!ch_en) m_err = 0;
      m_s2 = m_s1;
      m_s1 = dreq;
      if (cfg_we) m_w[cfg_line] = cfg_word;
    end
  end

  always @(negedge clk) begin
    lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    acc_ack <= ack_rand ? lfsr[0] : 1'b1;
    if (rst_n && cmp_on) begin
      chk(tag, "acc_req", 64'(acc_req), 64'(m_st == 1));
      if (m_st == 1) begin
        chk(tag, "acc_addr", 64'(acc_addr), 64'(m_a));
        chk(tag, "acc_size", 64'(acc_size), 64'(m_sz));
        chk(tag, "acc_write", 64'(acc_write), 64'(m_wr));
        chk(tag, "acc_swap", 64'(acc_swap), 64'(m_sw));
        chk(tag, "acc_port", 64'(acc_port), 64'(m_po));
      end
      chk(tag, "cfg_err", 64'(cfg_err), 64'(m_err));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wcfg(int line, logic [31:0] word);
    @(negedge clk);
    cfg_we = 1; cfg_line = line[4:0]; cfg_word = word;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, run hung");
    finish_run();
  end

  initial begin
    int seen;
    cyc(3);
    chk("R13", "acc_req in reset", 64'(acc_req), 0);
    chk("R13", "cfg_err in reset", 64'(cfg_err), 0);
    rst_n = 1;
    cyc(1);
    chk("R13", "acc_req after reset", 64'(acc_req), 0);
    cmp_on = 1;

    tag = "R1";
    wcfg(5, mk(3, 2, 1, 0, 1, 0, 2));
    ch_line = 5; ch_paced = 1; ch_en = 1;
    cyc(3);
    dreq[5] = 1;
    cyc(1); chk("R1", "acc_req one edge after request", 64'(acc_req), 0);
    cyc(1); chk("R1", "acc_req two edges after request", 64'(acc_req), 0);
    cyc(1); chk("R1", "acc_req three edges after request", 64'(acc_req), 1);
    tag = "R7";
    cyc(40);
    dreq[5] = 0; cyc(20);

    tag = "R2"; ack_rand = 1;
    wcfg(5, mk(2, 6, 1, 0, 1, 0, 0));
    dreq[5] = 1; cyc(4); dreq[5] = 0; cyc(30);

    tag = "R3";
    wcfg(5, mk(1, 0, 1, 0, 1, 1, 1));
    dreq[5] = 1; cyc(4); dreq[5] = 0; cyc(30);
    wcfg(5, mk(4, 4, 1, 0, 1, 0, 0));
    dreq[5] = 1; cyc(4); dreq[5] = 0; cyc(30);

    tag = "R5";
    wcfg(5, mk(3, 3, 1, 0, 0, 0, 1));
    dreq[5] = 1; cyc(4); dreq[5] = 0; cyc(30);

    tag = "R4";
    wcfg(5, mk(2, 1, 0, 0, 1, 0, 0));
    dreq[5] = 1; cyc(4); dreq[5] = 0; cyc(30);

    tag = "R6";
    wcfg(5, mk(1, 2, 1, 1, 1, 1, 0));
    dreq[5] = 1; cyc(4); dreq[5] = 0; cyc(30);

    tag = "R7";
    wcfg(5, mk(0, 2, 1, 0, 0, 0, 7));
    dreq[5] = 1; cyc(60); dreq[5] = 0; cyc(20);
    wcfg(5, mk(1, 2, 0, 0, 1, 0, 0));
    dreq[5] = 1; cyc(40); dreq[5] = 0; cyc(20);

    tag = "R8"; ack_rand = 0;
    dreq[9] = 1;
    for (int i = 0; i < 12; i++) begin
      cyc(1);
      chk("R8", "acc_req with other line active", 64'(acc_req), 0);
    end
    dreq[9] = 0;
    ch_en = 0; dreq[5] = 1; cyc(8);
    chk("R8", "acc_req while disabled", 64'(acc_req), 0);
    dreq[5] = 0; cyc(4);

    tag = "R9"; ack_rand = 1;
    wcfg(0, mk(1, 1, 1, 0, 1, 0, 3));
    ch_paced = 0; ch_en = 1;
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      cyc(1);
      if (acc_req) seen++;
    end
    chk("R9", "free-running bursts seen", 64'(seen > 0), 1);
    ch_en = 0; cyc(30);

    tag = "R10";
    ch_paced = 1; ch_line = 31; dreq[31] = 1; ch_en = 1;
    cyc(6);
    chk("R10", "acc_req on reserved top line", 64'(acc_req), 0);
    chk("R10", "cfg_err on reserved top line", 64'(cfg_err), 1);
    ch_en = 0; dreq[31] = 0; cyc(2);
    chk("R12", "cfg_err cleared by disable", 64'(cfg_err), 0);
    ch_line = 0; dreq[0] = 1; ch_en = 1; cyc(6);
    chk("R10", "acc_req on reserved line 0", 64'(acc_req), 0);
    chk("R10", "cfg_err on reserved line 0", 64'(cfg_err), 1);
    ch_en = 0; dreq[0] = 0; cyc(3);

    tag = "R11";
    wcfg(7, mk(0, 9, 1, 0, 1, 0, 0));
    ch_line = 7; dreq[7] = 1; ch_en = 1;
    cyc(8);
    chk("R11", "acc_req with bad width", 64'(acc_req), 0);
    chk("R11", "cfg_err with bad width", 64'(cfg_err), 1);
    tag = "R12";
    dreq[7] = 0; cyc(6);
    chk("R12", "cfg_err sticky while enabled", 64'(cfg_err), 1);
    ch_en = 0; cyc(2);
    chk("R12", "cfg_err after disable", 64'(cfg_err), 0);

    cyc(4);
    finish_run();
  end
endmodule